// File: doc/BRIEF.md
# Voltage Comparator Control and Interrupt Block

This block sits between a 32-bit register bus and an external analog voltage comparator. Software uses it to pick the comparator's positive and negative inputs and the internal reference level. It can power the comparator down behind a key value. It reads back the comparator's decision as status. Each change of the comparator's decision can raise an interrupt.

The comparator output arrives asynchronously. It passes through a two-flop synchronizer, and its rising and falling edges become two interrupt sources. Each source has its own enable, sticky status, write-one-to-clear and write-one-to-set bits, and the enabled sources are combined into one interrupt line. Selecting the temperature channel switches on the bandgap. It also starts a settle timer of `SETTLE_CYC` clock cycles, and comparator edges are discarded until that timer has run out.

The register bus is plain. A write takes effect on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr` and is always ready, so the bus has no back-pressure and no wait states. The analog pins are plain levels.

Top module: `vcmp_ctrl`

## Requirements
- R1: The configuration register at offset 0x000 stores the positive select in bits 1:0, the negative select in bits 9:8 and the reference level in bits 19:16. It drives them on `pos_sel`, `neg_sel` and `dac_level` from the cycle after the write. All other bits read 0, and every field resets to 0.
- R2: Bit 0 of the status register at offset 0x004 shows the comparator input delayed by two clock edges. Bit 1 shows the power-down state. All other bits read 0.
- R3: Writing 0x37 to the key register at offset 0x008 sets `cmp_pd` on the next edge. Writing any other value clears it. The key register reads 0, and `cmp_pd` resets to 0.
- R4: `bandgap_en` is high exactly while the positive select holds code 1, the temperature channel.
- R5: A configuration write that moves the positive select to code 1 from another code raises `cmp_settling` for exactly `SETTLE_CYC` cycles after the write edge. Rewriting code 1 while it is already selected does not restart the timer.
- R6: A rising edge of the synchronized comparator output sets interrupt status bit 1, the high source. A falling edge sets bit 0, the low source. The status bit is set one edge after the change shows in status bit 0.
- R7: Comparator edges set no status bit while `cmp_pd` is high or while `cmp_settling` is high.
- R8: Writing a 1 to a bit of the clear register at offset 0x208 clears the matching bit of the interrupt status at offset 0x204. Writing a 0 leaves that bit unchanged.
- R9: Writing a 1 to a bit of the set register at offset 0x20C sets the matching status bit. A set from hardware or from the bus wins over a clear of the same bit in the same cycle.
- R10: The enable register at offset 0x200 reads back its bits 1:0. `irq` is high when any status bit is set whose enable bit is also set.
- R11: The clear and set registers, and every unmapped offset, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| cmp_raw | input | 1 | Asynchronous comparator output, high when positive input exceeds negative |
| pos_sel | output | 2 | Positive input select to the analog mux |
| neg_sel | output | 2 | Negative input select to the analog mux |
| dac_level | output | 4 | Reference DAC level |
| bandgap_en | output | 1 | Bandgap enable, high while the temperature channel is selected |
| cmp_pd | output | 1 | Comparator power-down |
| cmp_settling | output | 1 | High while the reference settle timer runs |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions assume that `bus_we` is a one-cycle strobe with a stable address and data around the clock edge. They also assume that `cmp_raw` holds each level for at least three cycles, so that every edge it makes reaches the edge detector. The stimulus drives every bus field and `cmp_raw` only on falling clock edges. It holds `cmp_raw` steady during the random register phases, so that a hardware edge arrives only where a directed case expects one. The one deliberate overlap is a hardware edge that lands on the same edge as a clear of the same bit.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  // register byte offsets (fixed by software view)
  localparam int OFS_CFG    = 'h000;
  localparam int OFS_STAT   = 'h004;
  localparam int OFS_KEY    = 'h008;
  localparam int OFS_IEN    = 'h200;
  localparam int OFS_ISTAT  = 'h204;
  localparam int OFS_ICLR   = 'h208;
  localparam int OFS_ISET   = 'h20C;

  localparam logic [31:0] PD_KEY = 32'h0000_0037;

  // interrupt source bit positions
  localparam int IRQ_N  = 2;
  localparam int IRQ_LO = 0;
  localparam int IRQ_HI = 1;

  typedef enum logic [1:0] {
    PSEL_VADJ = 2'd0,
    PSEL_TEMP = 2'd1,
    PSEL_EXTA = 2'd2,
    PSEL_EXTB = 2'd3
  } psel_e;

  typedef struct packed {
    logic [3:0] lvl;
    logic [1:0] nsel;
    psel_e      psel;
  } cfg_t;
endpackage

// File: rtl/vcmp_sync.sv
module vcmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], din};
  end

  assign level = sh[STAGES-1];
  assign rise  =  sh[STAGES-1] & ~sh[STAGES];
  assign fall  = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/vcmp_settle.sv
module vcmp_settle #(
  parameter int CYC = 2200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int W = $clog2(CYC + 1);
  localparam logic [W-1:0] LOAD = W'(CYC);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (start)     cnt <= LOAD;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/vcmp_irq.sv
module vcmp_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] set_mask,
  input  logic [N-1:0] hw_evt,
  output logic [N-1:0] en,
  output logic [N-1:0] stat,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en[i]   <= 1'b0;
        stat[i] <= 1'b0;
      end else begin
        if (en_we) en[i] <= en_wdata[i];
        // a set from any origin wins over a clear in the same cycle
        if (set_mask[i] || hw_evt[i]) stat[i] <= 1'b1;
        else if (clr_mask[i])         stat[i] <= 1'b0;
      end
    end
  end

  assign irq = |(stat & en);
endmodule

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int SYNC_STG   = 2,
  parameter int SETTLE_CYC = 2200
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cmp_raw,
  output logic [1:0]        pos_sel,
  output logic [1:0]        neg_sel,
  output logic [3:0]        dac_level,
  output logic              bandgap_en,
  output logic              cmp_pd,
  output logic              cmp_settling,
  output logic              irq
);
  cfg_t cfg_q;
  logic pd_q;

  // address decode
  logic hit_cfg, hit_stat, hit_key, hit_ien, hit_istat, hit_iclr, hit_iset;
  assign hit_cfg   = (bus_addr == ADDR_W'(OFS_CFG));
  assign hit_stat  = (bus_addr == ADDR_W'(OFS_STAT));
  assign hit_key   = (bus_addr == ADDR_W'(OFS_KEY));
  assign hit_ien   = (bus_addr == ADDR_W'(OFS_IEN));
  assign hit_istat = (bus_addr == ADDR_W'(OFS_ISTAT));
  assign hit_iclr  = (bus_addr == ADDR_W'(OFS_ICLR));
  assign hit_iset  = (bus_addr == ADDR_W'(OFS_ISET));

  logic cfg_we;
  assign cfg_we = bus_we & hit_cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      pd_q  <= 1'b0;
    end else begin
      if (cfg_we) begin
        cfg_q.psel <= psel_e'(bus_wdata[1:0]);
        cfg_q.nsel <= bus_wdata[9:8];
        cfg_q.lvl  <= bus_wdata[19:16];
      end
      if (bus_we && hit_key) pd_q <= (bus_wdata == PD_KEY);
    end
  end

  // settle timer starts only on entry into the temperature channel
  logic settle_start, settle_busy;
  assign settle_start = cfg_we && (bus_wdata[1:0] == PSEL_TEMP) && (cfg_q.psel != PSEL_TEMP);

  vcmp_settle #(.CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (settle_start),
    .busy  (settle_busy)
  );

  logic cmp_lvl, cmp_rise, cmp_fall;
  vcmp_sync #(.STAGES(SYNC_STG)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cmp_raw),
    .level (cmp_lvl),
    .rise  (cmp_rise),
    .fall  (cmp_fall)
  );

  logic             edge_ok;
  logic [IRQ_N-1:0] hw_evt, clr_mask, set_mask, irq_en, irq_stat;
  assign edge_ok          = ~pd_q & ~settle_busy;
  assign hw_evt[IRQ_HI]   = edge_ok & cmp_rise;
  assign hw_evt[IRQ_LO]   = edge_ok & cmp_fall;
  assign clr_mask         = (bus_we && hit_iclr) ? bus_wdata[IRQ_N-1:0] : '0;
  assign set_mask         = (bus_we && hit_iset) ? bus_wdata[IRQ_N-1:0] : '0;

  vcmp_irq #(.N(IRQ_N)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_we    (bus_we & hit_ien),
    .en_wdata (bus_wdata[IRQ_N-1:0]),
    .clr_mask (clr_mask),
    .set_mask (set_mask),
    .hw_evt   (hw_evt),
    .en       (irq_en),
    .stat     (irq_stat),
    .irq      (irq)
  );

  // read mux; key, clear and set read as zero
  always_comb begin
    bus_rdata = '0;
    if (hit_cfg)   bus_rdata = {12'd0, cfg_q.lvl, 6'd0, cfg_q.nsel, 6'd0, cfg_q.psel};
    if (hit_stat)  bus_rdata = {30'd0, pd_q, cmp_lvl};
    if (hit_ien)   bus_rdata = {{(32-IRQ_N){1'b0}}, irq_en};
    if (hit_istat) bus_rdata = {{(32-IRQ_N){1'b0}}, irq_stat};
  end

  assign pos_sel      = cfg_q.psel;
  assign neg_sel      = cfg_q.nsel;
  assign dac_level    = cfg_q.lvl;
  assign bandgap_en   = (cfg_q.psel == PSEL_TEMP);
  assign cmp_pd       = pd_q;
  assign cmp_settling = settle_busy;
endmodule

// File: rtl/vcmp_ctrl_chk.sv
module vcmp_ctrl_chk
  import vcmp_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_we,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              cmp_pd,
  input logic              bandgap_en,
  input logic              cmp_settling,
  input logic              irq,
  input logic [1:0]        irq_en,
  input logic [1:0]        irq_stat,
  input logic [1:0]        hw_evt
);
  logic w_cfg, w_key, w_clr, w_set;
  assign w_cfg = bus_we && bus_addr == ADDR_W'(OFS_CFG);
  assign w_key = bus_we && bus_addr == ADDR_W'(OFS_KEY);
  assign w_clr = bus_we && bus_addr == ADDR_W'(OFS_ICLR);
  assign w_set = bus_we && bus_addr == ADDR_W'(OFS_ISET);

  p_key_pd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_key && bus_wdata == PD_KEY) |=> cmp_pd);
  p_key_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (w_key && bus_wdata != PD_KEY) |=> !cmp_pd);
  p_key_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(OFS_KEY)) |-> bus_rdata == 32'd0);
  p_bandgap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cfg && bus_wdata[1:0] == 2'd1) |=> bandgap_en);
  p_settle_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (w_cfg && bus_wdata[1:0] == 2'd1 && !bandgap_en) |=> cmp_settling);
  p_pd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_pd && !w_clr && !w_set) |=> $stable(irq_stat));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (w_clr && bus_wdata[1:0] == 2'b11 && hw_evt == 2'b00) |=> irq_stat == 2'b00);
  p_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (w_set && bus_wdata[1:0] == 2'b11) |=> irq_stat == 2'b11);
  p_irq_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_en == 2'b00) |-> !irq);
endmodule

bind vcmp_ctrl vcmp_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_addr     (bus_addr),
  .bus_we       (bus_we),
  .bus_wdata    (bus_wdata),
  .bus_rdata    (bus_rdata),
  .cmp_pd       (cmp_pd),
  .bandgap_en   (bandgap_en),
  .cmp_settling (cmp_settling),
  .irq          (irq),
  .irq_en       (irq_en),
  .irq_stat     (irq_stat),
  .hw_evt       (hw_evt)
);

// File: tb/vcmp_ctrl_test.sv
`timescale 1ns/1ps
module vcmp_ctrl_test;
  localparam int SETTLE = 2200;
  localparam logic [11:0] A_CFG = 12'h000, A_STAT = 12'h004, A_KEY = 12'h008,
    A_IEN = 12'h200, A_IST = 12'h204, A_ICLR = 12'h208, A_ISET = 12'h20C;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic cmp_raw = 1'b0;
  logic [1:0] pos_sel, neg_sel;
  logic [3:0] dac_level;
  logic bandgap_en, cmp_pd, cmp_settling, irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vcmp_ctrl #(.ADDR_W(12), .SETTLE_CYC(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_raw(cmp_raw),
    .pos_sel(pos_sel), .neg_sel(neg_sel), .dac_level(dac_level),
    .bandgap_en(bandgap_en), .cmp_pd(cmp_pd), .cmp_settling(cmp_settling),
    .irq(irq));

  function automatic logic [31:0] cfg_view(input logic [31:0] d);
    return d & 32'h000F_0303;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [11:0] a, input logic [31:0] exp);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [1:0] m_en, m_st;
    logic [31:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // reset state
    rd("R1 cfg reset", A_CFG, 32'd0);
    rd("R2 status reset", A_STAT, 32'd0);
    chk("R3 pd reset", {31'd0, cmp_pd}, 32'd0);
    chk("R10 irq reset", {31'd0, irq}, 32'd0);
    chk("R5 settling reset", {31'd0, cmp_settling}, 32'd0);

    // R1 directed and random configuration
    wr(A_CFG, 32'hFFFF_FFFE);
    rd("R1 cfg readback", A_CFG, 32'h000F_0302);
    chk("R1 pins", {24'd0, dac_level, neg_sel, pos_sel}, 32'h0000_00FE);
    for (int i = 0; i < 20; i++) begin
      d = $urandom;
      if (d[1:0] == 2'd1) d[1:0] = 2'd3;
      wr(A_CFG, d);
      rd("R1 cfg random", A_CFG, cfg_view(d));
      chk("R4 bandgap off", {31'd0, bandgap_en}, 32'd0);
    end

    // R11 write-only and unmapped offsets
    rd("R11 clear reads 0", A_ICLR, 32'd0);
    rd("R11 set reads 0", A_ISET, 32'd0);
    rd("R11 unmapped", 12'h100, 32'd0);
    rd("R3 key reads 0", A_KEY, 32'd0);

    // R3 key power-down, R7 edges ignored while down
    wr(A_KEY, 32'h37);
    chk("R3 pd on", {31'd0, cmp_pd}, 32'd1);
    rd("R2 status pd", A_STAT, 32'd2);
    wr(A_KEY, 32'h38);
    chk("R3 pd off", {31'd0, cmp_pd}, 32'd0);
    wr(A_KEY, 32'h37);
    cmp_raw = 1'b1;
    repeat (5) @(negedge clk);
    rd("R2 status level", A_STAT, 32'd3);
    cmp_raw = 1'b0;
    repeat (5) @(negedge clk);
    rd("R7 no edge while pd", A_IST, 32'd0);
    wr(A_KEY, 32'h0);

    // R6 edges, R2 timing, R8 clear
    wr(A_IEN, 32'h3);
    rd("R10 enable readback", A_IEN, 32'd3);
    cmp_raw = 1'b1;
    @(negedge clk); @(negedge clk);
    rd("R2 sync delay", A_STAT, 32'd1);
    rd("R6 not yet", A_IST, 32'd0);
    @(negedge clk);
    rd("R6 rise", A_IST, 32'd2);
    chk("R10 irq up", {31'd0, irq}, 32'd1);
    wr(A_ICLR, 32'h2);
    rd("R8 clear", A_IST, 32'd0);
    chk("R10 irq down", {31'd0, irq}, 32'd0);
    cmp_raw = 1'b0;
    repeat (3) @(negedge clk);
    rd("R6 fall", A_IST, 32'd1);
    wr(A_ICLR, 32'h0);
    rd("R8 zero no effect", A_IST, 32'd1);
    wr(A_ICLR, 32'h1);
    rd("R8 clear low", A_IST, 32'd0);

    // R9 hardware set beats same-cycle clear
    cmp_raw = 1'b1;
    @(negedge clk); @(negedge clk);
    wr(A_ICLR, 32'h2);
    rd("R9 set wins", A_IST, 32'd2);
    wr(A_ICLR, 32'h3);

    // R10 random register traffic against a model
    m_en = 2'b11; m_st = 2'b00;
    for (int i = 0; i < 40; i++) begin
      d = $urandom;
      case ($urandom % 3)
        0: begin wr(A_IEN, d); m_en = d[1:0]; end
        1: begin wr(A_ICLR, d); m_st = m_st & ~d[1:0]; end
        default: begin wr(A_ISET, d); m_st = m_st | d[1:0]; end
      endcase
      rd("R9 status model", A_IST, {30'd0, m_st});
      rd("R10 enable model", A_IEN, {30'd0, m_en});
      chk("R10 irq model", {31'd0, irq}, {31'd0, |(m_st & m_en)});
    end
    wr(A_ICLR, 32'h3);

    // R4/R5 temperature channel and settle window, R7 edges ignored meanwhile
    wr(A_CFG, 32'h1);
    chk("R4 bandgap on", {31'd0, bandgap_en}, 32'd1);
    chk("R5 settling start", {31'd0, cmp_settling}, 32'd1);
    cmp_raw = 1'b0;
    repeat (SETTLE - 1) @(negedge clk);
    chk("R5 settling last", {31'd0, cmp_settling}, 32'd1);
    rd("R7 no edge while settling", A_IST, 32'd0);
    @(negedge clk);
    chk("R5 settling end", {31'd0, cmp_settling}, 32'd0);
    wr(A_CFG, 32'h1);
    chk("R5 no restart", {31'd0, cmp_settling}, 32'd0);
    cmp_raw = 1'b1;
    repeat (3) @(negedge clk);
    rd("R7 edges resume", A_IST, 32'd2);
    wr(A_CFG, 32'h2);
    chk("R4 bandgap off", {31'd0, bandgap_en}, 32'd0);

    finish_run();
  end
endmodule